// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band

This block drives a pair of complementary switching outputs, a high-side line and a low-side line, from one fast clock. A runtime duty value sets the share of each period given to the high side. A runtime dead-band value, counted in whole clock cycles, keeps both lines inactive around every hand-over between the two sides. The period is a fixed number of clock cycles, 62 by default, so a duty of 31 gives half of each period. All timing has single-clock granularity.

An enable input starts a train of periods, and the train runs as long as enable stays high. Duty and dead-band are captured once when each period starts. When enable drops, the current period still runs to its end, trailing guard interval included. After that the outputs park in a safe state: high side low, low side high. A burst sequencer placed upstream can therefore cut the train at any cycle, and no hand-over ever skips its guard interval.

Top module: `cpwm_deadband`

## Requirements
- R1: A synchronous active-low reset forces `pwm_o`=0 and `pwmn_o`=1 on the next clock edge, even with `en_i` high. The period count is cleared.
- R2: While no period is running, `pwm_o`=0 and `pwmn_o`=1, whatever the duty and dead-band inputs are.
- R3: The first clock edge that sees `en_i` high starts a period at count 0. The outputs for count c appear after the (c+2)-th edge counted from that one. With `en_i` held high, periods of exactly PERIOD (62) cycles follow each other with no gap.
- R4: With sampled duty D and dead-band B, `pwm_o` is 1 at count c exactly when c >= B and c + B < D. A duty of 31 gives half of each period, less the guard intervals.
- R5: `pwmn_o` is 1 at count c exactly when c >= D + B and c + B < PERIOD.
- R6: A duty above PERIOD is treated as PERIOD. With B=0, a duty of 0 gives `pwmn_o` high for the whole period, and a full-scale duty gives `pwm_o` high for the whole period. If B is larger than a segment, that output stays low for the whole segment.
- R7: `pwm_o` and `pwmn_o` are never both 1. While a nonzero dead-band is in force, one output never rises on the same edge where the other falls.
- R8: A low `en_i` is acted on only at the last count of a period. The running period finishes unchanged, and the outputs go to the idle state one cycle after its last count is shown.
- R9: Duty and dead-band are captured at count 0 of each period. Changing them in the middle of a period changes nothing until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run request; periods repeat while high |
| duty_i | input | DUTY_W (6) | High-side length in clock cycles per period |
| dead_i | input | DB_W (4) | Guard interval in clock cycles |
| pwm_o | output | 1 | High-side drive, registered |
| pwmn_o | output | 1 | Low-side drive, registered |

## Verification
A period counter that skips or lingers on a count shows up in the very next period. The edges of both outputs land on the wrong cycles, and from the second period on the spacing between periods is wrong as well. If the settings were captured at the wrong moment, a period would carry a waveform mixing two settings, and the per-cycle comparison against the counting model reports that within one period. If the stop were handled early or late, the outputs would reach the idle pair one or more cycles before or after the end of the period. At the ports that is either a shortened low-side segment or an extra period.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // hi = high-side drive, lo = low-side drive
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    localparam pair_t PARK_PAIR = '{hi: 1'b0, lo: 1'b1};

    // true when first <= c < stop (signed so an empty window is harmless)
    function automatic logic in_span(input int c, input int first, input int stop);
        return (c >= first) && (c < stop);
    endfunction

endpackage

// File: rtl/cpwm_timer.sv
`timescale 1ns/1ps
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int PERIOD = 62,
    parameter int DUTY_W = 6,
    parameter int DB_W   = 4,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DB_W-1:0]   dead_i,
    output logic              run_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DB_W-1:0]   dead_o
);

    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(PERIOD - 1);
    localparam logic [DUTY_W-1:0] DUTY_TOP = DUTY_W'(PERIOD);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [DUTY_W-1:0] duty;
        logic [DB_W-1:0]   dead;
    } tstate_t;

    tstate_t s_d, s_q;
    logic    load;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            if (en_i) begin
                s_d.ph = PH_RUN;
                load   = 1'b1;
            end
        end else if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
            if (en_i) begin
                load = 1'b1;
            end else begin
                s_d.ph = PH_IDLE;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (load) begin
            s_d.cnt  = '0;
            s_d.duty = (duty_i > DUTY_TOP) ? DUTY_TOP : duty_i;
            s_d.dead = dead_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, duty: '0, dead: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o  = (s_q.ph == PH_RUN);
    assign cnt_o  = s_q.cnt;
    assign duty_o = s_q.duty;
    assign dead_o = s_q.dead;

    p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= LAST);

    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && s_q.cnt == LAST && en_i) |=> (run_o && s_q.cnt == '0));

    p_stop_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && s_q.cnt != LAST) |=> run_o);

    p_settings_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && s_q.cnt != '0) |-> ($stable(s_q.duty) && $stable(s_q.dead)));

    p_duty_clamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_o |-> (s_q.duty <= DUTY_TOP));

endmodule

// File: rtl/cpwm_shaper.sv
`timescale 1ns/1ps
module cpwm_shaper
    import cpwm_pkg::*;
#(
    parameter int PERIOD = 62,
    parameter int DUTY_W = 6,
    parameter int DB_W   = 4,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DB_W-1:0]   dead_i,
    output logic              pwm_o,
    output logic              pwmn_o
);

    typedef struct packed {
        pair_t out;
        logic  guard;   // nonzero dead-band in force for this output cycle
    } sstate_t;

    sstate_t s_d, s_q;
    int      c, d, b;

    always_comb begin
        c = int'(cnt_i);
        d = int'(duty_i);
        b = int'(dead_i);
        s_d.out   = PARK_PAIR;
        s_d.guard = 1'b0;
        if (run_i) begin
            s_d.out.hi = in_span(c, b, d - b);
            s_d.out.lo = in_span(c, d + b, PERIOD - b);
            s_d.guard  = (dead_i != '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{out: PARK_PAIR, guard: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o  = s_q.out.hi;
    assign pwmn_o = s_q.out.lo;

    p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pwm_o && pwmn_o));

    p_no_shared_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.guard && $past(s_q.guard)) |->
            !(($fell(pwm_o) && $rose(pwmn_o)) || ($rose(pwm_o) && $fell(pwmn_o))));

    p_park_when_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!pwm_o && pwmn_o));

endmodule

// File: rtl/cpwm_deadband.sv
`timescale 1ns/1ps
module cpwm_deadband #(
    parameter int PERIOD = 62,
    parameter int DUTY_W = 6,
    parameter int DB_W   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DB_W-1:0]   dead_i,
    output logic              pwm_o,
    output logic              pwmn_o
);

    localparam int CNT_W = $clog2(PERIOD);

    logic              run;
    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_s;
    logic [DB_W-1:0]   dead_s;

    cpwm_timer #(
        .PERIOD(PERIOD), .DUTY_W(DUTY_W), .DB_W(DB_W), .CNT_W(CNT_W)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .duty_i (duty_i),
        .dead_i (dead_i),
        .run_o  (run),
        .cnt_o  (cnt),
        .duty_o (duty_s),
        .dead_o (dead_s)
    );

    cpwm_shaper #(
        .PERIOD(PERIOD), .DUTY_W(DUTY_W), .DB_W(DB_W), .CNT_W(CNT_W)
    ) u_shaper (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .cnt_i  (cnt),
        .duty_i (duty_s),
        .dead_i (dead_s),
        .pwm_o  (pwm_o),
        .pwmn_o (pwmn_o)
    );

    p_reset_park_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!pwm_o && pwmn_o));

endmodule

// File: tb/cpwm_deadband_bench.sv
`timescale 1ns/1ps
module cpwm_deadband_bench;

    localparam int P  = 62;
    localparam int NV = 12;
    // each entry: {duty[9:4], dead[3:0]}
    localparam logic [9:0] VEC [NV] = '{
        {6'd31, 4'd0}, {6'd31, 4'd2}, {6'd31, 4'd3}, {6'd10, 4'd2},
        {6'd0,  4'd0}, {6'd0,  4'd3}, {6'd62, 4'd0}, {6'd63, 4'd2},
        {6'd5,  4'd3}, {6'd31, 4'd15}, {6'd50, 4'd4}, {6'd1,  4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [5:0] duty;
    logic [3:0] dead;
    logic       pwm, pwmn;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    int         overlap = 0;
    int         shared = 0;

    always #2 clk = ~clk;

    cpwm_deadband u_cpwm_deadband (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .duty_i(duty),
        .dead_i(dead), .pwm_o(pwm), .pwmn_o(pwmn)
    );

    function automatic logic [1:0] model(input int c, input int d, input int b);
        int  dd = (d > P) ? P : d;
        logic hi = (c >= b) && (c + b < dd);
        logic lo = (c >= dd + b) && (c + b < P);
        return {hi, lo};
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwm,pwmn actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // one period from idle; enable dropped and settings scrambled mid-period
    task automatic run_vec(input int d, input int b);
        logic [1:0] prev = 2'b01;
        logic [1:0] now;
        duty = 6'(d); dead = 4'(b); en = 1'b1;
        step();
        chk("R3 idle one cycle after enable", {pwm, pwmn}, 2'b01);
        for (int c = 0; c < P; c++) begin
            step();
            now = {pwm, pwmn};
            chk($sformatf("R4 R5 R6 duty %0d dead %0d count %0d", d, b, c), now, model(c, d, b));
            if (now == 2'b11) overlap++;
            if (b != 0 && c != 0 && now != prev && now[1] != prev[1] && now[0] != prev[0]) shared++;
            prev = now;
            if (c == 20) begin
                en = 1'b0; duty = ~6'(d); dead = ~4'(b);
            end
        end
        step();
        chk("R8 idle after last count", {pwm, pwmn}, 2'b01);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; duty = '0; dead = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {pwm, pwmn}, 2'b01);
        en = 1'b1; duty = 6'd31; dead = 4'd2;
        step();
        chk("R1 reset overrides enable", {pwm, pwmn}, 2'b01);
        rst_n = 1'b1; en = 1'b0;

        for (int i = 0; i < 8; i++) begin
            duty = 6'(i * 9); dead = 4'(i);
            step();
            chk("R2 idle ignores settings", {pwm, pwmn}, 2'b01);
        end

        for (int v = 0; v < NV; v++) begin
            run_vec(int'(VEC[v][9:4]), int'(VEC[v][3:0]));
        end
        chk("R7 never both high", {1'b0, overlap != 0}, 2'b00);
        chk("R7 no shared edge with dead-band", {1'b0, shared != 0}, 2'b00);

        // back-to-back periods, mid-period change applies next period
        duty = 6'd31; dead = 4'd2; en = 1'b1;
        step();
        for (int c = 0; c < P; c++) begin
            step();
            chk($sformatf("R9 first period count %0d", c), {pwm, pwmn}, model(c, 31, 2));
            if (c == 10) begin duty = 6'd10; dead = 4'd0; end
        end
        for (int c = 0; c < P; c++) begin
            step();
            chk($sformatf("R3 R9 second period count %0d", c), {pwm, pwmn}, model(c, 10, 0));
            if (c == 5) en = 1'b0;
        end
        step();
        chk("R8 stop after second period", {pwm, pwmn}, 2'b01);

        // reset in mid-period, then restart from count zero
        duty = 6'd31; dead = 4'd0; en = 1'b1;
        repeat (12) step();
        rst_n = 1'b0;
        step();
        chk("R1 reset mid-period", {pwm, pwmn}, 2'b01);
        rst_n = 1'b1;
        step();
        chk("R3 idle before restart output", {pwm, pwmn}, 2'b01);
        step();
        chk("R3 restart at count zero", {pwm, pwmn}, model(0, 31, 0));
        en = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule